// File: doc/BRIEF.md
# Flash Write-Enable and Protection Unit

This block stands between the command front-end of a serial NOR flash and its storage array. It decides whether each modifying request (page program, sector erase, whole-array erase, status write) may go ahead. The front-end has already shifted the serial bits and decoded the instruction, so the block receives a decoded opcode and a 24-bit address. Acceptance needs three things: a prior write-enable, a target outside the region that the three protect bits cover, and, for status writes, no hardware lock. The hardware lock holds when the status-lock bit is set while the write-protect pin is held low.

An accepted request raises a busy flag for a programmable number of clock cycles and then clears the write-enable latch. A refused request also clears the latch, and it never starts a busy period. The block holds a model of the array with flash bit rules. Programming can only turn ones into zeros, and erasing returns bytes to 0xFF. Program bytes stream in after the program request and wrap inside their page.

Top module: `fwp_top`

## Requirements
- R1: After reset the write-enable latch, busy, the three protect bits and the status-lock bit are all 0, and every array byte reads 0xFF.
- R2: When idle, opcode 0 (enable) sets the write-enable latch and opcode 1 (disable) clears it.
- R3: Opcodes 2 (program), 3 (sector erase), 4 (whole erase) and 5 (status write) are refused when the latch is 0. A refusal pulses `rej` one cycle after the request and changes neither the array nor the status bits.
- R4: Protect value 0 protects no sector. Value 1 protects the top sector only, 2 the top 2, 3 the top 4, 4 the top 8 and 5 the top 16 of the 32 sectors. Values 6 and 7 protect all 32.
- R5: A program or sector erase whose address falls in a protected sector is refused. A whole erase is refused whenever any protect bit is 1.
- R6: A status write is refused when the status-lock bit is 1 and `wp_n` is 0. In every other case it is accepted after enable and loads `cmd_bp` and `cmd_srwd`.
- R7: Each program byte is ANDed into the stored byte. The column advances by one per byte and wraps from the last byte of the page back to its first byte. Address bits above the array size are ignored.
- R8: A sector erase sets every byte of the addressed sector to 0xFF and leaves all other bytes unchanged. A whole erase sets every byte to 0xFF.
- R9: `busy` stays high for exactly `op_cycles` cycles, or for one cycle when `op_cycles` is 0. It rises in the cycle after an erase or status write is accepted, or after the `load_end` beat of a program. The latch reads 0 when busy falls and reads 1 while busy is high.
- R10: While busy, or while program bytes are being loaded, requests are ignored. A refusal clears the latch.
- R11: `acc` and `rej` are single-cycle pulses that follow a modifying request by one cycle, and never both at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Decoded request present this cycle |
| cmd_op | input | 3 | Opcode: 0 enable, 1 disable, 2 program, 3 sector erase, 4 whole erase, 5 status write |
| cmd_addr | input | CMD_AW | Target byte address |
| cmd_bp | input | 3 | Protect bits for a status write |
| cmd_srwd | input | 1 | Status-lock bit for a status write |
| data_valid | input | 1 | Program data byte present |
| data_byte | input | 8 | Program data byte |
| load_end | input | 1 | Final program beat (chip select rose) |
| wp_n | input | 1 | Write-protect pin, active low |
| op_cycles | input | CNT_W | Busy length in cycles |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array byte at rd_addr |
| wel | output | 1 | Write-enable latch |
| busy | output | 1 | Modifying cycle in progress |
| bp | output | 3 | Protect bits |
| srwd | output | 1 | Status-lock bit |
| acc | output | 1 | Request accepted pulse |
| rej | output | 1 | Request refused pulse |

## Verification
The bench builds the block with 4-byte pages, 2 pages per sector and 32 sectors. That gives a 256-byte array, small enough for the bench to hold a full copy and compare every byte after each change. With the sector count kept at 32, every protect value can be swept against every sector, covering all 256 pairs. Page wrap can be reached after only a handful of bytes. Short busy lengths let the bench count the exact busy width, including the zero case.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
    typedef enum logic [2:0] {
        OP_WEN    = 3'd0,
        OP_WDIS   = 3'd1,
        OP_PROG   = 3'd2,
        OP_SERASE = 3'd3,
        OP_WERASE = 3'd4,
        OP_STATWR = 3'd5
    } fwp_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_BUSY = 2'd2
    } fwp_st_e;
endpackage

// File: rtl/fwp_prot_map.sv
module fwp_prot_map #(
    parameter int SECTORS = 32,
    parameter int SEC_W   = 5
) (
    input  logic [2:0]       bp,
    input  logic [SEC_W-1:0] sector,
    output logic             prot
);
    // Lowest protected sector index; SECTORS means nothing protected.
    logic [SEC_W:0] thr;

    always_comb begin
        case (bp)
            3'd0:    thr = (SEC_W+1)'(SECTORS);
            3'd1:    thr = (SEC_W+1)'(SECTORS - SECTORS / 32);
            3'd2:    thr = (SEC_W+1)'(SECTORS - SECTORS / 16);
            3'd3:    thr = (SEC_W+1)'(SECTORS - SECTORS / 8);
            3'd4:    thr = (SEC_W+1)'(SECTORS - SECTORS / 4);
            3'd5:    thr = (SEC_W+1)'(SECTORS - SECTORS / 2);
            default: thr = '0;
        endcase
        prot = ({1'b0, sector} >= thr);
    end
endmodule

// File: rtl/fwp_array.sv
module fwp_array #(
    parameter int BYTES     = 256,
    parameter int SEC_BYTES = 8,
    parameter int ADDR_W    = 8,
    parameter int SEC_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_byte,
    input  logic              se_en,
    input  logic [SEC_W-1:0]  se_idx,
    input  logic              be_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    logic [BYTES-1:0][7:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_addr] = mem_q[wr_addr] & wr_byte;
        end
        if (se_en) begin
            for (int i = 0; i < BYTES; i++) begin
                if (SEC_W'(i / SEC_BYTES) == se_idx) begin
                    mem_d[i] = 8'hFF;
                end
            end
        end
        if (be_en) begin
            mem_d = '1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '1;
        else        mem_q <= mem_d;
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/fwp_top.sv
module fwp_top
    import fwp_pkg::*;
#(
    parameter int PAGE_BYTES    = 4,
    parameter int PAGES_PER_SEC = 2,
    parameter int SECTORS       = 32,
    parameter int CMD_AW        = 24,
    parameter int CNT_W         = 8,
    localparam int SEC_BYTES    = PAGE_BYTES * PAGES_PER_SEC,
    localparam int BYTES        = SEC_BYTES * SECTORS,
    localparam int ADDR_W       = $clog2(BYTES),
    localparam int PG_W         = $clog2(PAGE_BYTES),
    localparam int SEC_W        = $clog2(SECTORS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [CMD_AW-1:0] cmd_addr,
    input  logic [2:0]        cmd_bp,
    input  logic              cmd_srwd,
    input  logic              data_valid,
    input  logic [7:0]        data_byte,
    input  logic              load_end,
    input  logic              wp_n,
    input  logic [CNT_W-1:0]  op_cycles,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              wel,
    output logic              busy,
    output logic [2:0]        bp,
    output logic              srwd,
    output logic              acc,
    output logic              rej
);
    typedef struct packed {
        fwp_st_e                  st;
        logic                     wel;
        logic [2:0]               bp;
        logic                     srwd;
        logic [CNT_W-1:0]         cnt;
        logic [ADDR_W-PG_W-1:0]   page;
        logic [PG_W-1:0]          col;
        logic                     acc;
        logic                     rej;
    } ctl_t;

    ctl_t d, q;

    logic [ADDR_W-1:0] a_low;
    logic [SEC_W-1:0]  a_sec;
    logic              a_prot;
    logic              hw_lock;
    logic [CNT_W-1:0]  run_len;
    logic              wr_en, se_en, be_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [1:0]        st_obs;
    logic              unused_hi;

    assign a_low     = cmd_addr[ADDR_W-1:0];
    assign a_sec     = a_low[ADDR_W-1 -: SEC_W];
    assign unused_hi = ^cmd_addr[CMD_AW-1:ADDR_W];
    assign hw_lock   = q.srwd && !wp_n;
    assign run_len   = (op_cycles == '0) ? CNT_W'(1) : op_cycles;
    assign wr_addr   = {q.page, q.col};
    assign st_obs    = q.st;

    fwp_prot_map #(.SECTORS(SECTORS), .SEC_W(SEC_W)) u_map (
        .bp     (q.bp),
        .sector (a_sec),
        .prot   (a_prot)
    );

    always_comb begin
        d     = q;
        d.acc = 1'b0;
        d.rej = 1'b0;
        wr_en = 1'b0;
        se_en = 1'b0;
        be_en = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    case (cmd_op)
                        OP_WEN:  d.wel = 1'b1;
                        OP_WDIS: d.wel = 1'b0;
                        OP_PROG: begin
                            if (q.wel && !a_prot) begin
                                d.acc  = 1'b1;
                                d.st   = ST_LOAD;
                                d.page = a_low[ADDR_W-1:PG_W];
                                d.col  = a_low[PG_W-1:0];
                            end else begin
                                d.rej = 1'b1;
                                d.wel = 1'b0;
                            end
                        end
                        OP_SERASE: begin
                            if (q.wel && !a_prot) begin
                                d.acc = 1'b1;
                                se_en = 1'b1;
                                d.st  = ST_BUSY;
                                d.cnt = run_len;
                            end else begin
                                d.rej = 1'b1;
                                d.wel = 1'b0;
                            end
                        end
                        OP_WERASE: begin
                            if (q.wel && q.bp == 3'd0) begin
                                d.acc = 1'b1;
                                be_en = 1'b1;
                                d.st  = ST_BUSY;
                                d.cnt = run_len;
                            end else begin
                                d.rej = 1'b1;
                                d.wel = 1'b0;
                            end
                        end
                        OP_STATWR: begin
                            if (q.wel && !hw_lock) begin
                                d.acc  = 1'b1;
                                d.bp   = cmd_bp;
                                d.srwd = cmd_srwd;
                                d.st   = ST_BUSY;
                                d.cnt  = run_len;
                            end else begin
                                d.rej = 1'b1;
                                d.wel = 1'b0;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            ST_LOAD: begin
                if (data_valid) begin
                    wr_en = 1'b1;
                    d.col = q.col + PG_W'(1);
                end
                if (load_end) begin
                    d.st  = ST_BUSY;
                    d.cnt = run_len;
                end
            end
            ST_BUSY: begin
                if (q.cnt <= CNT_W'(1)) begin
                    d.st  = ST_IDLE;
                    d.wel = 1'b0;
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    fwp_array #(
        .BYTES(BYTES), .SEC_BYTES(SEC_BYTES), .ADDR_W(ADDR_W), .SEC_W(SEC_W)
    ) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_byte (data_byte),
        .se_en   (se_en),
        .se_idx  (a_sec),
        .be_en   (be_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    assign wel  = q.wel;
    assign busy = (q.st == ST_BUSY);
    assign bp   = q.bp;
    assign srwd = q.srwd;
    assign acc  = q.acc;
    assign rej  = q.rej;
endmodule

// File: rtl/fwp_chk.sv
module fwp_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [2:0] cmd_op,
    input logic       wp_n,
    input logic       wel,
    input logic       busy,
    input logic [2:0] bp,
    input logic       srwd,
    input logic       acc,
    input logic       rej,
    input logic [1:0] st
);
    logic idle;
    logic modop;
    assign idle  = (st == 2'd0);
    assign modop = (cmd_op >= 3'd2) && (cmd_op <= 3'd5);

    assert_busy_holds_wel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> wel);

    assert_done_clears_wel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);

    assert_single_verdict_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc && rej));

    assert_refusal_drops_wel_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rej |-> !wel);

    assert_no_latch_no_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && idle && !wel && modop) |=> (rej && !acc));

    assert_hw_lock_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && idle && cmd_op == 3'd5 && srwd && !wp_n)
        |=> (rej && bp == $past(bp) && srwd == $past(srwd)));

    assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> (!acc && !rej));
endmodule

bind fwp_top fwp_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .wp_n      (wp_n),
    .wel       (wel),
    .busy      (busy),
    .bp        (bp),
    .srwd      (srwd),
    .acc       (acc),
    .rej       (rej),
    .st        (st_obs)
);

// File: tb/tb_fwp_top.sv
module tb_fwp_top;
    localparam int CLK_PERIOD = 10;
    localparam int PB   = 4;
    localparam int PPS  = 2;
    localparam int NSEC = 32;
    localparam int SECB = PB * PPS;
    localparam int NB   = SECB * NSEC;
    localparam int AW   = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [23:0] cmd_addr = '0;
    logic [2:0]  cmd_bp = '0;
    logic        cmd_srwd = 1'b0;
    logic        data_valid = 1'b0;
    logic [7:0]  data_byte = '0;
    logic        load_end = 1'b0;
    logic        wp_n = 1'b1;
    logic [7:0]  op_cycles = 8'd1;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]  rd_data;
    logic        wel, busy, srwd, acc, rej;
    logic [2:0]  bp;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] model [NB];

    always #(CLK_PERIOD/2) clk = ~clk;

    fwp_top #(.PAGE_BYTES(PB), .PAGES_PER_SEC(PPS), .SECTORS(NSEC)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_bp(cmd_bp), .cmd_srwd(cmd_srwd),
        .data_valid(data_valid), .data_byte(data_byte), .load_end(load_end),
        .wp_n(wp_n), .op_cycles(op_cycles), .rd_addr(rd_addr), .rd_data(rd_data),
        .wel(wel), .busy(busy), .bp(bp), .srwd(srwd), .acc(acc), .rej(rej)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_cmd(input logic [2:0] op, input logic [23:0] a,
                          input logic [2:0] b, input logic s);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_bp = b; cmd_srwd = s;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v, input logic last);
        data_valid = 1'b1; data_byte = v; load_end = last;
        @(negedge clk);
        data_valid = 1'b0; load_end = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic mem_check(input string req);
        int bad_at = -1;
        logic [7:0] got = '0;
        for (int i = 0; i < NB; i++) begin
            rd_addr = AW'(i);
            #1;
            if (rd_data !== model[i] && bad_at < 0) begin
                bad_at = i; got = rd_data;
            end
        end
        chk(bad_at < 0, req, $sformatf("array byte %0d", bad_at), got,
            (bad_at < 0) ? 0 : model[bad_at]);
    endtask

    task automatic set_status(input logic [2:0] b, input logic s);
        do_cmd(3'd0, 24'h0, 3'd0, 1'b0);
        do_cmd(3'd5, 24'h0, b, s);
        wait_idle();
    endtask

    function automatic bit expect_prot(input int b, input int sec);
        int cnt;
        if (b == 0)      cnt = 0;
        else if (b >= 6) cnt = NSEC;
        else             cnt = 1 << (b - 1);
        return sec >= NSEC - cnt;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < NB; i++) model[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(wel == 0 && busy == 0, "R1", "wel/busy", {wel, busy}, 0);
        chk(bp == 0 && srwd == 0, "R1", "bp/srwd", {bp, srwd}, 0);
        mem_check("R1");

        // R2 enable / disable
        do_cmd(3'd0, 24'h0, 3'd0, 1'b0);
        chk(wel == 1, "R2", "wel after enable", wel, 1);
        do_cmd(3'd1, 24'h0, 3'd0, 1'b0);
        chk(wel == 0, "R2", "wel after disable", wel, 0);

        // R3 refusals without latch
        for (int op = 2; op <= 5; op++) begin
            do_cmd(3'(op), 24'h10, 3'd3, 1'b1);
            chk(rej == 1 && acc == 0, "R3", $sformatf("op %0d verdict", op), {acc, rej}, 1);
            @(negedge clk);
            chk(busy == 0, "R3", "no busy", busy, 0);
        end
        chk(bp == 0 && srwd == 0, "R3", "status untouched", {bp, srwd}, 0);
        mem_check("R3");

        // R7 program with wrap and high address bits ignored
        op_cycles = 8'd2;
        do_cmd(3'd0, 24'h0, 3'd0, 1'b0);
        do_cmd(3'd2, 24'hE00005, 3'd0, 1'b0);
        chk(acc == 1, "R11", "program accept pulse", acc, 1);
        send_byte(8'hA5, 1'b0);
        chk(acc == 0, "R11", "accept pulse width", acc, 0);
        chk(busy == 0, "R10", "no busy while loading", busy, 0);
        send_byte(8'h3C, 1'b0);
        send_byte(8'h0F, 1'b0);
        send_byte(8'hF0, 1'b0);
        send_byte(8'h12, 1'b1);
        model[5] = 8'hA5 & 8'h12; model[6] = 8'h3C; model[7] = 8'h0F; model[4] = 8'hF0;
        chk(busy == 1, "R9", "busy after load end", busy, 1);
        wait_idle();
        chk(wel == 0, "R9", "latch cleared after program", wel, 0);
        mem_check("R7");
        do_cmd(3'd0, 24'h0, 3'd0, 1'b0);
        do_cmd(3'd2, 24'h000006, 3'd0, 1'b0);
        send_byte(8'hF0, 1'b1);
        model[6] = 8'h3C & 8'hF0;
        wait_idle();
        mem_check("R7");

        // R9 busy widths
        for (int n = 0; n <= 5; n += 5) begin
            int w;
            int expw;
            op_cycles = 8'(n);
            expw = (n == 0) ? 1 : n;
            do_cmd(3'd0, 24'h0, 3'd0, 1'b0);
            do_cmd(3'd3, 24'(3 * SECB), 3'd0, 1'b0);
            w = 0;
            while (busy) begin
                chk(wel == 1, "R9", "latch held while busy", wel, 1);
                w++;
                @(negedge clk);
            end
            chk(w == expw, "R9", "busy width", w, expw);
            chk(wel == 0, "R9", "latch after busy", wel, 0);
        end

        // R8 sector erase of programmed sector 0
        op_cycles = 8'd1;
        do_cmd(3'd0, 24'h0, 3'd0, 1'b0);
        do_cmd(3'd2, 24'(9 * SECB + 2), 3'd0, 1'b0);
        send_byte(8'h5A, 1'b1);
        model[9 * SECB + 2] = 8'h5A;
        wait_idle();
        do_cmd(3'd0, 24'h0, 3'd0, 1'b0);
        do_cmd(3'd3, 24'h000003, 3'd0, 1'b0);
        for (int i = 0; i < SECB; i++) model[i] = 8'hFF;
        wait_idle();
        mem_check("R8");
        do_cmd(3'd0, 24'h0, 3'd0, 1'b0);
        do_cmd(3'd4, 24'h0, 3'd0, 1'b0);
        chk(acc == 1, "R8", "whole erase accepted", acc, 1);
        model[9 * SECB + 2] = 8'hFF;
        wait_idle();
        mem_check("R8");

        // R10 requests ignored while busy
        op_cycles = 8'd6;
        do_cmd(3'd0, 24'h0, 3'd0, 1'b0);
        do_cmd(3'd3, 24'h0, 3'd0, 1'b0);
        do_cmd(3'd1, 24'h0, 3'd0, 1'b0);
        chk(wel == 1, "R10", "disable ignored while busy", wel, 1);
        do_cmd(3'd5, 24'h0, 3'd7, 1'b1);
        chk(acc == 0 && rej == 0, "R10", "status write ignored while busy", {acc, rej}, 0);
        wait_idle();
        chk(bp == 0, "R10", "bp untouched by ignored write", bp, 0);
        op_cycles = 8'd1;

        // R6 hardware lock
        set_status(3'd0, 1'b1);
        chk(srwd == 1, "R6", "lock bit set", srwd, 1);
        wp_n = 1'b0;
        do_cmd(3'd0, 24'h0, 3'd0, 1'b0);
        do_cmd(3'd5, 24'h0, 3'd3, 1'b0);
        chk(rej == 1, "R6", "locked write refused", rej, 1);
        chk(bp == 0 && srwd == 1, "R6", "status kept", {bp, srwd}, 1);
        chk(wel == 0, "R10", "refusal clears latch", wel, 0);
        wp_n = 1'b1;
        set_status(3'd0, 1'b0);
        chk(srwd == 0, "R6", "unlocked write accepted", srwd, 0);

        // R4/R5 full sweep of protect value against sector
        for (int b = 0; b < 8; b++) begin
            set_status(3'(b), 1'b0);
            chk(bp == 3'(b), "R4", "bp loaded", bp, b);
            for (int s = 0; s < NSEC; s++) begin
                bit p;
                p = expect_prot(b, s);
                do_cmd(3'd0, 24'h0, 3'd0, 1'b0);
                do_cmd(3'd3, 24'(s * SECB + 1), 3'd0, 1'b0);
                chk(acc == !p && rej == p, "R4",
                    $sformatf("erase bp %0d sector %0d", b, s), {acc, rej}, {!p, p});
                if (p) chk(wel == 0, "R5", "refused erase clears latch", wel, 0);
                wait_idle();
            end
            do_cmd(3'd0, 24'h0, 3'd0, 1'b0);
            do_cmd(3'd4, 24'h0, 3'd0, 1'b0);
            chk(acc == (b == 0), "R5", $sformatf("whole erase bp %0d", b), acc, (b == 0));
            wait_idle();
        end
        // bp is 7 now: program anywhere is refused
        do_cmd(3'd0, 24'h0, 3'd0, 1'b0);
        do_cmd(3'd2, 24'h000000, 3'd0, 1'b0);
        chk(rej == 1, "R5", "program into protected sector", rej, 1);
        send_byte(8'h00, 1'b1);
        mem_check("R5");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule